// File: doc/BRIEF.md
# Indirect Switch Register Bridge

This block lets a management host reach a switch's wide internal registers through a narrow register port. The port carries 5-bit register numbers and 16-bit data as parallel strobes, as an MDIO-style management agent would present them after it has decoded the serial frames. A few pseudo-PHY registers form a small indirection window: a page register, a command register that carries the in-page offset and a read or write request, and four 16-bit data words that together hold one 64-bit value.

A host write first loads the data words and then sets the write request. A host read sets the read request, polls until the request bits read back clear, and then collects the data words. Narrower values use only the low words: an 8-bit value sits in the low byte of the lowest word, and a 48-bit value spans the lowest three words. The bridge drives a request/acknowledge handshake on an internal bus with an 8-bit page, an 8-bit offset and 64-bit data. A small register file answers on that bus, so the bridge can be checked with nothing else attached.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the page register, the command register and all four data words read 0x0000, and every internal register holds 0.
- R2: Register 0x10 reads {page[7:0], 7'b0, pageEnable}. Register 0x11 reads {offset[7:0], 6'b0, readBit, writeBit}. Registers 0x18 to 0x1B read the data words, with 0x18 holding bits 15:0 of the wide value and each higher number holding the next 16 bits. Any other register number reads 0xFFFF.
- R3: Writing 0x11 with bits 1:0 = 01 while page enable is set stores the value {0x1B,0x1A,0x19,0x18} at the selected page and offset. The offset comes from bits 15:8.
- R4: Writing 0x11 with bits 1:0 = 10 while page enable is set loads the four data words from the selected internal register once the command completes.
- R5: An accepted command bit reads back as set for exactly BUSY_CYCLES+2 clock cycles, counted from the write edge, and then reads back as clear.
- R6: A command with both bits set is ignored. The command bits read 00 from the next cycle, and no internal access takes place.
- R7: If page enable is 0, a command is dropped. The command bits read 00 and no internal access takes place.
- R8: Writes to the data words while a command is busy have no effect.
- R9: Writes to register 0x11 while a command is busy have no effect. This covers both the offset and the command.
- R10: An access uses the page and offset held in the registers when its command was accepted. Later changes to the page register do not affect it.
- R11: The internal register file covers pages below RF_PAGES and offsets below RF_OFFSETS. Reads outside that range return 0, and writes outside it are discarded without aliasing onto stored entries.
- R12: The internal request stays high until it is acknowledged. An acknowledge lasts one cycle and only comes while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mgmtWrEn | input | 1 | Register write strobe, one cycle per write |
| mgmtRegNum | input | 5 | Register number for writes and reads |
| mgmtWrData | input | 16 | Write data |
| mgmtRdData | output | 16 | Read data for mgmtRegNum, combinational |

## Verification
The bench builds the bridge with BUSY_CYCLES=3, RF_PAGES=2 and RF_OFFSETS=4. With these values the eight stored entries can each be written and read back with distinct patterns, the full 32-entry register number space can be swept, and the busy window is long enough to inject data, command and page writes during it. Page 3 and offset 7 lie outside the file, and page 2 would alias page 0 if only low address bits were decoded, so both show whether the range rule holds.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 4;
  localparam int WIDE_W    = WORD_W * NUM_WORDS;
  localparam int PAGE_W    = 8;
  localparam int OFS_W     = 8;
  localparam int REGNUM_W  = 5;

  localparam logic [REGNUM_W-1:0] REG_PAGE      = 5'h10;
  localparam logic [REGNUM_W-1:0] REG_CMD       = 5'h11;
  localparam logic [REGNUM_W-1:0] REG_DATA_BASE = 5'h18;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;      // a command is in flight
    logic latchAddr; // capture offset and page for a command write
    logic loadRd;    // load data words from the internal read value
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_REQ} ctlState_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REGNUM_W-1:0] regNum,
  input  logic [1:0]          cmdOp,
  input  logic                pageEn,
  input  logic                intAck,
  output ctlStrobe_t          strobe,
  output logic [1:0]          cmdBits,
  output logic                intReq,
  output logic                intWe
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] holdCnt;
  logic             cmdWr;
  logic             opValid;
  logic             start;

  assign cmdWr   = wrEn && (regNum == REG_CMD);
  assign opValid = (cmdOp == 2'b01) || (cmdOp == 2'b10);
  assign start   = cmdWr && (state == ST_IDLE) && pageEn && opValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
      cmdBits <= 2'b00;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_HOLD;
            holdCnt <= '0;
            cmdBits <= cmdOp;
          end
        end
        ST_HOLD: begin
          if (holdCnt == CNT_W'(BUSY_CYCLES - 1)) state <= ST_REQ;
          else holdCnt <= holdCnt + 1'b1;
        end
        ST_REQ: begin
          if (intAck) begin
            state   <= ST_IDLE;
            cmdBits <= 2'b00;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign intReq           = (state == ST_REQ);
  assign intWe            = cmdBits[0];
  assign strobe.busy      = (state != ST_IDLE);
  assign strobe.latchAddr = cmdWr && (state == ST_IDLE);
  assign strobe.loadRd    = intReq && intAck && cmdBits[1];

  p_cmd_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdBits));
  p_drop_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (state == ST_IDLE) && !pageEn) |=> !strobe.busy);
  p_busy_shows_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busy |-> (cmdBits != 2'b00));
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq);
endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REGNUM_W-1:0] regNum,
  input  logic [WORD_W-1:0]   wrData,
  input  ctlStrobe_t          strobe,
  input  logic [1:0]          cmdBits,
  input  logic [WIDE_W-1:0]   rdWide,
  output logic [WORD_W-1:0]   rdData,
  output logic                pageEn,
  output logic [PAGE_W-1:0]   accPage,
  output logic [OFS_W-1:0]    accOfs,
  output logic [WIDE_W-1:0]   wrWide
);
  logic [PAGE_W-1:0] pageNum;
  logic [WORD_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageNum <= '0;
      pageEn  <= 1'b0;
      accOfs  <= '0;
      accPage <= '0;
    end else begin
      if (wrEn && (regNum == REG_PAGE)) begin
        pageNum <= wrData[15:8];
        pageEn  <= wrData[0];
      end
      if (strobe.latchAddr) begin
        accOfs  <= wrData[15:8];
        accPage <= pageNum;
      end
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) words[i] <= '0;
      else if (strobe.loadRd) words[i] <= rdWide[i*WORD_W +: WORD_W];
      else if (wrEn && !strobe.busy && (regNum == REG_DATA_BASE + REGNUM_W'(i)))
        words[i] <= wrData;
    end
    assign wrWide[i*WORD_W +: WORD_W] = words[i];
  end

  always_comb begin
    rdData = 16'hFFFF;
    if (regNum == REG_PAGE) rdData = {pageNum, 7'b0, pageEn};
    else if (regNum == REG_CMD) rdData = {accOfs, 6'b0, cmdBits};
    else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (regNum == REG_DATA_BASE + REGNUM_W'(i)) rdData = words[i];
    end
  end

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !strobe.loadRd) |=> $stable(wrWide));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !strobe.latchAddr) |=> ($stable(accOfs) && $stable(accPage)));
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
  import bridge_pkg::*;
#(
  parameter int RF_PAGES   = 2,
  parameter int RF_OFFSETS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WIDE_W-1:0] wdata,
  output logic              ack,
  output logic [WIDE_W-1:0] rdata
);
  localparam int DEPTH = RF_PAGES * RF_OFFSETS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDE_W-1:0] mem [DEPTH];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit = (int'(page) < RF_PAGES) && (int'(ofs) < RF_OFFSETS);
  assign idx = IDX_W'(int'(page) * RF_OFFSETS + int'(ofs));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack   <= 1'b0;
      rdata <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        ack   <= 1'b1;
        rdata <= hit ? mem[idx] : '0;
        if (hit && we) mem[idx] <= wdata;
      end
    end
  end

  p_ack_needs_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> req);
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import bridge_pkg::*;
#(
  parameter int BUSY_CYCLES = 2,
  parameter int RF_PAGES    = 2,
  parameter int RF_OFFSETS  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mgmtWrEn,
  input  logic [4:0]  mgmtRegNum,
  input  logic [15:0] mgmtWrData,
  output logic [15:0] mgmtRdData
);
  ctlStrobe_t        strobe;
  logic [1:0]        cmdBits;
  logic              intReq, intWe, intAck, pageEn;
  logic [PAGE_W-1:0] accPage;
  logic [OFS_W-1:0]  accOfs;
  logic [WIDE_W-1:0] wrWide, rdWide;

  bridge_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(mgmtWrEn), .regNum(mgmtRegNum),
    .cmdOp(mgmtWrData[1:0]), .pageEn(pageEn), .intAck(intAck),
    .strobe(strobe), .cmdBits(cmdBits), .intReq(intReq), .intWe(intWe)
  );

  bridge_dpath u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(mgmtWrEn), .regNum(mgmtRegNum),
    .wrData(mgmtWrData), .strobe(strobe), .cmdBits(cmdBits),
    .rdWide(rdWide), .rdData(mgmtRdData), .pageEn(pageEn),
    .accPage(accPage), .accOfs(accOfs), .wrWide(wrWide)
  );

  bridge_regfile #(.RF_PAGES(RF_PAGES), .RF_OFFSETS(RF_OFFSETS)) u_rf (
    .clk(clk), .rstN(rstN), .req(intReq), .we(intWe), .page(accPage),
    .ofs(accOfs), .wdata(wrWide), .ack(intAck), .rdata(rdWide)
  );
endmodule

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 3;
  localparam int PAGES      = 2;
  localparam int OFFSETS    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mgmtWrEn = 1'b0;
  logic [4:0]  mgmtRegNum = '0;
  logic [15:0] mgmtWrData = '0;
  logic [15:0] mgmtRdData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  ind_reg_bridge #(.BUSY_CYCLES(BUSY), .RF_PAGES(PAGES), .RF_OFFSETS(OFFSETS)) u_dut (
    .clk(clk), .rstN(rstN), .mgmtWrEn(mgmtWrEn), .mgmtRegNum(mgmtRegNum),
    .mgmtWrData(mgmtWrData), .mgmtRdData(mgmtRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mgmtWrEn = 1'b1; mgmtRegNum = r; mgmtWrData = d;
    @(negedge clk);
    mgmtWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [4:0] r, output logic [15:0] d);
    mgmtRegNum = r;
    #1 d = mgmtRdData;
  endtask

  // counts cycles with command bits set, starting at the negedge after the issue edge
  task automatic waitDone(output int n);
    logic [15:0] v;
    n = 0;
    regRd(5'h11, v);
    while (v[1:0] != 2'b00 && n < 60) begin
      n++;
      @(negedge clk);
      regRd(5'h11, v);
    end
  endtask

  task automatic setPage(input logic [7:0] p, input logic en);
    regWr(5'h10, {p, 7'b0, en});
  endtask

  task automatic loadWords(input logic [63:0] v);
    for (int i = 0; i < 4; i++) regWr(5'h18 + 5'(i), v[i*16 +: 16]);
  endtask

  task automatic memWrite(input logic [7:0] p, input logic [7:0] o, input logic [63:0] v, output int n);
    setPage(p, 1'b1);
    loadWords(v);
    regWr(5'h11, {o, 8'h01});
    waitDone(n);
  endtask

  task automatic memRead(input logic [7:0] p, input logic [7:0] o, output logic [63:0] v, output int n);
    logic [15:0] w;
    setPage(p, 1'b1);
    loadWords(64'h0);
    regWr(5'h11, {o, 8'h02});
    waitDone(n);
    for (int i = 0; i < 4; i++) begin
      regRd(5'h18 + 5'(i), w);
      v[i*16 +: 16] = w;
    end
  endtask

  function automatic logic [63:0] pattern(input int p, input int o);
    return 64'h0123_4567_89AB_CDEF ^ (64'(p * OFFSETS + o + 1) * 64'h0001_0003_0007_000F);
  endfunction

  initial begin
    logic [15:0] v;
    logic [63:0] w;
    int n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(5'h10, v); check("R1 page reg", v, 16'h0);
    regRd(5'h11, v); check("R1 cmd reg", v, 16'h0);
    for (int i = 0; i < 4; i++) begin
      regRd(5'h18 + 5'(i), v); check("R1 data word", v, 16'h0);
    end
    for (int p = 0; p < PAGES; p++)
      for (int o = 0; o < OFFSETS; o++) begin
        memRead(8'(p), 8'(o), w, n); check("R1 internal reg", w, 64'h0);
      end

    // R2 unmapped numbers
    for (int r = 0; r < 32; r++) begin
      if (r != 16 && r != 17 && !(r >= 24 && r <= 27)) begin
        regRd(5'(r), v); check("R2 unmapped reads FFFF", v, 16'hFFFF);
      end
    end
    setPage(8'hA5, 1'b1);
    regRd(5'h10, v); check("R2 page readback", v, 16'hA501);
    loadWords(64'h4444_3333_2222_1111);
    for (int i = 0; i < 4; i++) begin
      regRd(5'h18 + 5'(i), v); check("R2 word order", v, 16'(16'h1111 * (i + 1)));
    end

    // R3 / R4 / R5 sweep of all entries
    for (int p = 0; p < PAGES; p++)
      for (int o = 0; o < OFFSETS; o++) begin
        memWrite(8'(p), 8'(o), pattern(p, o), n);
        check("R5 write busy length", n, BUSY + 2);
      end
    for (int p = 0; p < PAGES; p++)
      for (int o = 0; o < OFFSETS; o++) begin
        memRead(8'(p), 8'(o), w, n);
        check("R5 read busy length", n, BUSY + 2);
        check("R3 R4 stored value", w, pattern(p, o));
        regRd(5'h11, v); check("R2 cmd readback idle", v, {8'(o), 8'h00});
      end

    // R6 both bits set
    setPage(8'h00, 1'b1);
    loadWords(64'hAAAA_AAAA_AAAA_AAAA);
    regWr(5'h11, 16'h0003);
    regRd(5'h11, v); check("R6 both bits cleared", v, 16'h0000);
    memRead(8'h00, 8'h00, w, n); check("R6 no access", w, pattern(0, 0));

    // R7 page enable clear
    setPage(8'h00, 1'b0);
    loadWords(64'h5555_5555_5555_5555);
    regWr(5'h11, 16'h0101);
    regRd(5'h11, v); check("R7 command dropped", v, 16'h0100);
    memRead(8'h00, 8'h01, w, n); check("R7 no access", w, pattern(0, 1));

    // R8 / R9 writes during busy
    setPage(8'h00, 1'b1);
    loadWords(64'hCAFE_F00D_1234_5678);
    regWr(5'h11, 16'h0201);
    regWr(5'h18, 16'hBEEF);
    regWr(5'h11, 16'h0302);
    waitDone(n);
    regRd(5'h18, v); check("R8 data write ignored while busy", v, 16'h5678);
    regRd(5'h11, v); check("R9 cmd write ignored while busy", v, 16'h0200);
    memRead(8'h00, 8'h02, w, n); check("R8 stored value intact", w, 64'hCAFE_F00D_1234_5678);
    memRead(8'h00, 8'h03, w, n); check("R9 no second access", w, pattern(0, 3));

    // R10 page latched at accept
    setPage(8'h01, 1'b1);
    loadWords(64'h0);
    regWr(5'h11, 16'h0102);
    setPage(8'h00, 1'b1);
    waitDone(n);
    for (int i = 0; i < 4; i++) begin
      regRd(5'h18 + 5'(i), v); w[i*16 +: 16] = v;
    end
    check("R10 page at accept", w, pattern(1, 1));

    // R11 range limits
    memWrite(8'h02, 8'h00, 64'hDEAD_DEAD_DEAD_DEAD, n);
    memRead(8'h00, 8'h00, w, n); check("R11 no alias page", w, pattern(0, 0));
    memRead(8'h02, 8'h00, w, n); check("R11 out of range page", w, 64'h0);
    memWrite(8'h00, 8'h07, 64'hBAD0_BAD0_BAD0_BAD0, n);
    memRead(8'h00, 8'h07, w, n); check("R11 out of range offset", w, 64'h0);
    memRead(8'h01, 8'h03, w, n); check("R11 no alias offset", w, pattern(1, 3));

    // R12 handshake completes for a last access
    memWrite(8'h01, 8'h02, 64'h0000_0000_0000_00FF, n);
    check("R12 completes", n, BUSY + 2);
    memRead(8'h01, 8'h02, w, n); check("R12 byte in low word", w, 64'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule